// File: doc/BRIEF.md
# Register-Write Command Stream Executor

This block replays a queue of register-write instructions kept in memory onto an internal register bus. Software enables the engine, loads a start pointer, then writes an end pointer; that last write launches execution. The engine reads the queue one 64-bit word at a time through a simple fixed-latency read port. It decodes each word and issues the resulting writes on a valid/ready output port. It reports busy until the end of the queue, or until it meets an instruction it cannot decode.

Two instruction kinds exist. The first is a single write carrying its own byte enables. The second is a burst of values all aimed at one auto-increment register. Bursts are packed at dword granularity and padded so that every instruction begins on a 64-bit boundary. Whole zero words act as no-ops, so the filler between the last instruction and the cache-line-rounded end costs only fetch cycles.

Top module: `cmd_stream_exec`

## Requirements
- R1: After reset, busy, enable and error read as 0, and neither wrValid nor memRdEn is asserted.
- R2: A word whose upper dword has opcode 0x01 in bits 31:24 produces one bus write. Its address is upper bits 19:0, its byte enables are upper bits 23:20, and its data is the lower dword.
- R3: A word whose upper dword has opcode 0x09 starts a burst. The lower dword is a count N, and upper bits 19:0 are the target address. The next N dwords are written in order (lower dword of each word first) to that address with byte enables 0xF. For odd N, the spare upper dword is skipped. N = 0 produces no writes. The next instruction begins at the following word.
- R4: A 64-bit word that is entirely zero outside a burst produces no bus write.
- R5: A write to the end pointer while enable is 1 and the engine is idle starts execution. Fetching begins at the start pointer with its bits 2:0 treated as zero. It continues up to the end pointer rounded up to a multiple of 64 bytes, so the last fetch address is that rounded value minus 8.
- R6: While wrValid is high and wrReady is low, wrAddr, wrData and wrByteEn hold steady and memRdEn stays low.
- R7: Any other opcode sets a sticky error bit, ends execution with busy cleared, and produces no further writes. Writing the control register with bit 2 set while idle clears the error bit.
- R8: While busy, writes to the control register, the start pointer and the end pointer are ignored.
- R9: A write to the end pointer while enable is 0 stores the value but starts nothing.
- R10: Register map by regAddr: 0 is control (bit 0 enable read/write, bit 1 busy read-only, bit 2 error), 1 is the start pointer, 2 is the end pointer, and 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| memRdEn | output | 1 | Memory read request |
| memRdAddr | output | PTR_W | Byte address of the requested 64-bit word |
| memRdData | input | 64 | Read data, valid the cycle after memRdEn |
| wrValid | output | 1 | Bus write valid |
| wrReady | input | 1 | Bus write accepted |
| wrAddr | output | 20 | Bus write register offset |
| wrData | output | 32 | Bus write data |
| wrByteEn | output | 4 | Bus write byte enables |

## Verification
A mixed queue is run first with the bus always ready and then with random backpressure. The queue holds direct writes with full and partial byte enables, an odd burst, an even burst, an empty burst and a zero word. The always-ready run separates decoding faults from handshake faults, and the backpressure run exposes lost or repeated writes and fetches issued during stalls. A queue with an unaligned end pointer and an instruction placed just past the stated end, but inside the rounded line, shows whether the rounding is applied. A queue with a bad opcode between two valid writes shows where execution stops. Finally, register writes made during a fully stalled run show that the control state is locked while busy.

// File: rtl/cse_pkg.sv
package cse_pkg;
  localparam int OFF_W = 20;

  localparam logic [7:0] OP_DIRECT  = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_HEAD = 2'd1;
  localparam logic [1:0] REG_TAIL = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LATCH, S_DECODE, S_DIRECT, S_BLO, S_BHI
  } engState_t;

  typedef enum logic [1:0] {
    EMIT_NONE, EMIT_DIRECT, EMIT_LO, EMIT_HI
  } emitSel_t;

  typedef struct packed {
    logic start;
    logic fetch;
    logic latch;
    logic loadBurst;
    logic stepBurst;
    logic endBurst;
  } dpCtl_t;
endpackage

// File: rtl/cse_datapath.sv
module cse_datapath
  import cse_pkg::*;
#(
  parameter int PTR_W      = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  emitSel_t          emitSel,
  input  logic              busy,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [PTR_W-1:0]  ptrWd,
  input  logic [63:0]       memRdData,
  output logic [PTR_W-1:0]  memRdAddr,
  output logic [PTR_W-1:0]  headQ,
  output logic [PTR_W-1:0]  tailQ,
  output logic              atEnd,
  output logic              wordZero,
  output logic [7:0]        opcode,
  output logic              countZero,
  output logic              countOne,
  output logic              inBurst,
  output logic [OFF_W-1:0]  wrAddr,
  output logic [31:0]       wrData,
  output logic [3:0]        wrByteEn
);
  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam logic [PTR_W-1:0] WORD_STEP = PTR_W'(8);
  localparam logic [PTR_W-1:0] LINE_ADD  = PTR_W'(LINE_BYTES - 1);

  logic [PTR_W-1:0] curPtr, endPtr, tailSum, tailRounded;
  logic [63:0]      wordReg;
  logic [31:0]      burstCnt;
  logic [OFF_W-1:0] burstOff;
  logic             headWr, tailWr;

  assign headWr      = regWrEn && (regAddr == REG_HEAD) && !busy;
  assign tailWr      = regWrEn && (regAddr == REG_TAIL) && !busy;
  assign tailSum     = ptrWd + LINE_ADD;
  assign tailRounded = {tailSum[PTR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ  <= '0;
      tailQ  <= '0;
      curPtr <= '0;
      endPtr <= '0;
    end else begin
      if (headWr) headQ <= {ptrWd[PTR_W-1:3], 3'b000};
      if (tailWr) tailQ <= ptrWd;
      if (ctl.start) begin
        curPtr <= headQ;
        endPtr <= tailRounded;
      end else if (ctl.latch) begin
        curPtr <= curPtr + WORD_STEP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordReg  <= '0;
      burstCnt <= '0;
      burstOff <= '0;
      inBurst  <= 1'b0;
    end else begin
      if (ctl.latch) wordReg <= memRdData;
      if (ctl.start || ctl.endBurst) begin
        inBurst <= 1'b0;
      end else if (ctl.loadBurst) begin
        inBurst  <= 1'b1;
        burstCnt <= wordReg[31:0];
        burstOff <= wordReg[32 +: OFF_W];
      end else if (ctl.stepBurst) begin
        burstCnt <= burstCnt - 32'd1;
      end
    end
  end

  assign memRdAddr = curPtr;
  assign atEnd     = (curPtr >= endPtr);
  assign wordZero  = (wordReg == 64'd0);
  assign opcode    = wordReg[63:56];
  assign countZero = (wordReg[31:0] == 32'd0);
  assign countOne  = (burstCnt == 32'd1);

  always_comb begin
    wrAddr   = burstOff;
    wrData   = wordReg[31:0];
    wrByteEn = 4'hF;
    case (emitSel)
      EMIT_DIRECT: begin
        wrAddr   = wordReg[32 +: OFF_W];
        wrByteEn = wordReg[55:52];
      end
      EMIT_HI: wrData = wordReg[63:32];
      default: ;
    endcase
  end

  p_fetch_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fetch |-> (curPtr < endPtr));

  p_head_locked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && regAddr == REG_HEAD) |=> $stable(headQ));
endmodule

// File: rtl/cse_control.sv
module cse_control
  import cse_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic       enableWd,
  input  logic       clrErrWd,
  input  logic       wrReady,
  input  logic       atEnd,
  input  logic       wordZero,
  input  logic [7:0] opcode,
  input  logic       countZero,
  input  logic       countOne,
  input  logic       inBurst,
  output dpCtl_t     ctl,
  output emitSel_t   emitSel,
  output logic       wrValid,
  output logic       memRdEn,
  output logic       busy,
  output logic       enableQ,
  output logic       errQ
);
  engState_t state, nxt;
  logic      setErr;

  assign busy    = (state != S_IDLE);
  assign wrValid = (emitSel != EMIT_NONE);

  always_comb begin
    ctl     = '0;
    nxt     = state;
    memRdEn = 1'b0;
    emitSel = EMIT_NONE;
    setErr  = 1'b0;
    case (state)
      S_IDLE:
        if (regWrEn && regAddr == REG_TAIL && enableQ) begin
          ctl.start = 1'b1;
          nxt       = S_FETCH;
        end
      S_FETCH:
        if (atEnd) begin
          ctl.endBurst = 1'b1;
          nxt          = S_IDLE;
        end else begin
          memRdEn   = 1'b1;
          ctl.fetch = 1'b1;
          nxt       = S_LATCH;
        end
      S_LATCH: begin
        ctl.latch = 1'b1;
        nxt       = inBurst ? S_BLO : S_DECODE;
      end
      S_DECODE:
        if (wordZero) begin
          nxt = S_FETCH;
        end else if (opcode == OP_DIRECT) begin
          nxt = S_DIRECT;
        end else if (opcode == OP_INDEXED) begin
          ctl.loadBurst = !countZero;
          nxt           = S_FETCH;
        end else begin
          setErr = 1'b1;
          nxt    = S_IDLE;
        end
      S_DIRECT: begin
        emitSel = EMIT_DIRECT;
        if (wrReady) nxt = S_FETCH;
      end
      S_BLO: begin
        emitSel = EMIT_LO;
        if (wrReady) begin
          ctl.stepBurst = 1'b1;
          if (countOne) begin
            ctl.endBurst = 1'b1;
            nxt          = S_FETCH;
          end else begin
            nxt = S_BHI;
          end
        end
      end
      S_BHI: begin
        emitSel = EMIT_HI;
        if (wrReady) begin
          ctl.stepBurst = 1'b1;
          ctl.endBurst  = countOne;
          nxt           = S_FETCH;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      enableQ <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      state <= nxt;
      if (setErr) begin
        errQ <= 1'b1;
      end else if (regWrEn && regAddr == REG_CTRL && !busy && clrErrWd) begin
        errQ <= 1'b0;
      end
      if (regWrEn && regAddr == REG_CTRL && !busy) enableQ <= enableWd;
    end
  end

  p_error_stops_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> !busy);

  p_start_needs_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(enableQ) && $past(regWrEn) && $past(regAddr) == REG_TAIL));
endmodule

// File: rtl/cmd_stream_exec.sv
module cmd_stream_exec
  import cse_pkg::*;
#(
  parameter int PTR_W      = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memRdEn,
  output logic [PTR_W-1:0]  memRdAddr,
  input  logic [63:0]       memRdData,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [19:0]       wrAddr,
  output logic [31:0]       wrData,
  output logic [3:0]        wrByteEn
);
  dpCtl_t           ctl;
  emitSel_t         emitSel;
  logic             busy, enableQ, errQ;
  logic             atEnd, wordZero, countZero, countOne, inBurst;
  logic [7:0]       opcode;
  logic [PTR_W-1:0] headQ, tailQ;
  logic             unusedWdBits;

  assign unusedWdBits = ^{regWrData[31:PTR_W], regWrData[1]};

  cse_control u_ctrl (
    .clk, .rstN, .regWrEn, .regAddr,
    .enableWd(regWrData[0]), .clrErrWd(regWrData[2]),
    .wrReady, .atEnd, .wordZero, .opcode, .countZero, .countOne, .inBurst,
    .ctl, .emitSel, .wrValid, .memRdEn, .busy, .enableQ, .errQ
  );

  cse_datapath #(.PTR_W(PTR_W), .LINE_BYTES(LINE_BYTES)) u_dp (
    .clk, .rstN, .ctl, .emitSel, .busy, .regWrEn, .regAddr,
    .ptrWd(regWrData[PTR_W-1:0]), .memRdData,
    .memRdAddr, .headQ, .tailQ, .atEnd, .wordZero, .opcode,
    .countZero, .countOne, .inBurst, .wrAddr, .wrData, .wrByteEn
  );

  always_comb begin
    case (regAddr)
      REG_CTRL: regRdData = {29'd0, errQ, busy, enableQ};
      REG_HEAD: regRdData = {{(32-PTR_W){1'b0}}, headQ};
      REG_TAIL: regRdData = {{(32-PTR_W){1'b0}}, tailQ};
      default:  regRdData = 32'd0;
    endcase
  end

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable({wrAddr, wrData, wrByteEn})));

  p_no_fetch_in_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> !memRdEn);
endmodule

// File: tb/cmd_stream_exec_bench.sv
module cmd_stream_exec_bench;
  logic        clk = 0;
  logic        rstN = 0;
  logic        regWrEn = 0;
  logic [1:0]  regAddr = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] regRdData;
  logic        memRdEn;
  logic [15:0] memRdAddr;
  logic [63:0] memRdData = 0;
  logic        wrValid;
  logic        wrReady = 1;
  logic [19:0] wrAddr;
  logic [31:0] wrData;
  logic [3:0]  wrByteEn;

  cmd_stream_exec u_cmd_stream_exec (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0, readyMode = 0;
  int fetchCnt = 0, maxFetch = -1;
  logic [63:0] mem [0:255];
  logic [55:0] expQ [$];
  logic        prevStall = 0;
  logic [55:0] prevFields;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finishRun();
    end
  end

  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memRdAddr[10:3]];
    wrReady <= (readyMode == 0) ? 1'b1 : (readyMode == 1) ? ($urandom % 3 != 0) : 1'b0;
  end

  // Monitor: compares each accepted write to the model queue; checks stalls.
  always @(negedge clk) if (rstN) begin
    if (memRdEn) begin
      fetchCnt++;
      if (int'(memRdAddr) > maxFetch) maxFetch = int'(memRdAddr);
      chk(!wrValid, "R6 fetch during write", 1, 0);
    end
    if (prevStall)
      chk(wrValid && {wrAddr, wrByteEn, wrData} == prevFields, "R6 stall hold",
          {wrAddr, wrByteEn, wrData}, prevFields);
    if (wrValid && wrReady) begin
      if (expQ.size() == 0) chk(0, "R2/R3/R4 unexpected write", {wrAddr, wrByteEn, wrData}, 0);
      else begin
        logic [55:0] e;
        e = expQ.pop_front();
        chk({wrAddr, wrByteEn, wrData} == e, "R2/R3 write content", {wrAddr, wrByteEn, wrData}, e);
      end
    end
    prevStall  = wrValid && !wrReady;
    prevFields = {wrAddr, wrByteEn, wrData};
  end

  function automatic logic [31:0] dw(input int idx);
    return idx[0] ? mem[idx >> 1][63:32] : mem[idx >> 1][31:0];
  endfunction

  task automatic putWord(input int byteAddr, input logic [31:0] hi, input logic [31:0] lo);
    mem[byteAddr >> 3] = {hi, lo};
  endtask

  // Behavioural model: walks the dword stream and queues expected writes.
  task automatic buildExp(input int head, input int tail, output bit expErr);
    int i, endD;
    logic [31:0] lo, hi;
    expErr = 0;
    i = (head & ~7) / 4;
    endD = ((tail + 63) / 64) * 64 / 4;
    while (i < endD) begin
      lo = dw(i); hi = dw(i + 1);
      i += 2;
      if (lo == 0 && hi == 0) continue;
      if (hi[31:24] == 8'h01) expQ.push_back({hi[19:0], hi[23:20], lo});
      else if (hi[31:24] == 8'h09) begin
        for (int k = 0; k < int'(lo); k++) begin
          if (i >= endD) break;
          expQ.push_back({hi[19:0], 4'hF, dw(i)});
          i++;
        end
        if (i[0]) i++;
      end else begin
        expErr = 1;
        break;
      end
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] c;
    for (int n = 0; n < 3000; n++) begin
      regRead(2'd0, c);
      if (!c[1]) break;
    end
  endtask

  task automatic runProg(input int head, input int tail, input string tag);
    bit expErr;
    logic [31:0] c;
    int lastAddr;
    buildExp(head, tail, expErr);
    regWrite(2'd1, head);
    maxFetch = -1;
    regWrite(2'd2, tail);
    waitIdle();
    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, {"R2/R3 all writes seen ", tag}, expQ.size(), 0);
    regRead(2'd0, c);
    chk(c[2] == expErr, {"R7 error bit ", tag}, c[2], expErr);
    chk(c[1] == 0, {"R5 busy clear ", tag}, c[1], 0);
    lastAddr = ((tail + 63) / 64) * 64 - 8;
    if (!expErr) chk(maxFetch == lastAddr, {"R5 last fetch ", tag}, maxFetch, lastAddr);
    expQ.delete();
  endtask

  initial begin
    logic [31:0] r;
    for (int w = 0; w < 256; w++) mem[w] = 64'd0;

    // Queue A at 0x000: direct, direct (partial BE), burst 3, zero, burst 2, burst 0, direct
    putWord('h00, {8'h01, 4'hF, 20'h00100}, 32'hA5A5_0001);
    putWord('h08, {8'h01, 4'h3, 20'h00104}, 32'h1234_5678);
    putWord('h10, {8'h09, 4'h0, 20'h00200}, 32'd3);
    putWord('h18, 32'h22, 32'h11);
    putWord('h20, 32'h0, 32'h33);
    putWord('h30, {8'h09, 4'h0, 20'h00300}, 32'd2);
    putWord('h38, 32'h55, 32'h44);
    putWord('h40, {8'h09, 4'h0, 20'h00380}, 32'd0);
    putWord('h48, {8'h01, 4'hF, 20'h00400}, 32'hDEAD_BEEF);
    // Queue B at 0x200: end pointer 0x208 rounds to 0x240
    putWord('h200, {8'h01, 4'hF, 20'h00500}, 32'h0000_0B01);
    putWord('h230, {8'h01, 4'h8, 20'h00504}, 32'h0000_0B02);
    putWord('h240, {8'h01, 4'hF, 20'h00508}, 32'h0000_0BFF);
    // Queue C at 0x300: bad opcode in the middle
    putWord('h300, {8'h01, 4'hF, 20'h00600}, 32'h0000_0C01);
    putWord('h308, {8'h05, 4'hF, 20'h00604}, 32'h0000_0C02);
    putWord('h310, {8'h01, 4'hF, 20'h00608}, 32'h0000_0C03);
    // Queue D at 0x400: four direct writes
    for (int k = 0; k < 4; k++) putWord('h400 + 8 * k, {8'h01, 4'hF, 20'h00700 + 20'(k)}, 32'h0D00 + k);

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!wrValid && !memRdEn, "R1 outputs idle in reset", {wrValid, memRdEn}, 0);
    rstN = 1;
    regRead(2'd0, r);
    chk(r[2:0] == 3'b000, "R1 ctrl after reset", r[2:0], 0);

    // R10: map readback, R9: end pointer write with enable 0
    regWrite(2'd1, 32'h0000_0000);
    regWrite(2'd2, 32'h0000_0050);
    repeat (8) @(negedge clk);
    regRead(2'd0, r);
    chk(r[1] == 0 && fetchCnt == 0, "R9 no start while disabled", fetchCnt, 0);
    regRead(2'd2, r);
    chk(r == 32'h50, "R10 end pointer readback", r, 32'h50);
    regRead(2'd3, r);
    chk(r == 0, "R10 unused address reads zero", r, 0);
    regWrite(2'd0, 32'h1);
    regRead(2'd0, r);
    chk(r[0] == 1, "R10 enable readback", r[0], 1);

    // R2/R3/R4 with a ready bus, then with random backpressure (R6)
    readyMode = 0;
    runProg('h000, 'h50, "queue A ready");
    readyMode = 1;
    runProg('h000, 'h50, "queue A backpressure");

    // R5: unaligned start pointer and end pointer rounding
    readyMode = 0;
    runProg('h203, 'h208, "queue B rounding");
    regRead(2'd1, r);
    chk(r == 32'h200, "R5 start pointer low bits dropped", r, 32'h200);

    // R7: bad opcode stops, error sticky, then cleared
    runProg('h300, 'h340, "queue C bad opcode");
    regWrite(2'd0, 32'h5);
    regRead(2'd0, r);
    chk(r[2] == 0 && r[0] == 1, "R7 error cleared", r[2:0], 3'b001);

    // R8: writes while busy are ignored (bus held not ready)
    buildExp('h400, 'h420, r[0]);
    regWrite(2'd1, 'h400);
    readyMode = 2;
    regWrite(2'd2, 'h420);
    repeat (6) @(negedge clk);
    regWrite(2'd1, 'h600);
    regWrite(2'd0, 32'h0);
    regWrite(2'd2, 'h7C0);
    regRead(2'd1, r);
    chk(r == 'h400, "R8 start pointer locked", r, 'h400);
    regRead(2'd0, r);
    chk(r[1:0] == 2'b11, "R8 enable locked while busy", r[1:0], 2'b11);
    regRead(2'd2, r);
    chk(r == 'h420, "R8 end pointer locked", r, 'h420);
    readyMode = 0;
    waitIdle();
    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, "R8 run completes after stall", expQ.size(), 0);

    finishRun();
  end
endmodule